// File: doc/BRIEF.md
# Watchdog and Interrupt Combiner for a Real-Time Clock

This block sits beside a real-time clock. It holds a programmable watchdog down-counter that is clocked by a 32 Hz tick. It also keeps three sticky event flags: watchdog expiry, alarm match and power fail. It merges the enabled flags into one interrupt pin. Host software programs two 8-bit registers through a single-cycle write port. One is the watchdog register and one is the interrupt-control register. Software reads the flags through a read strobe, and that strobe also clears them.

The pin has a programmable polarity and two modes. In level mode the pin stays active while any enabled flag is set, so it releases once the host reads the flags. In pulse mode each enabled event starts a pulse that lasts a fixed number of 32 Hz ticks. The parameter default is 6 ticks, about 190 ms. The pulse does not depend on flag reads and is meant to reset a host.

None of the interfaces carry a data stream, so every pin is a plain control or status signal. Writes and the read strobe take effect in the cycle they are asserted, and there is no back-pressure.

Top module: `wdog_irq_unit`

## Requirements
- R1: After reset all flags read 0, the watchdog timeout is 0 and its lock bit is 0. All enables are off, the polarity is active-low and the mode is level, so `irq_pin` is 1.
- R2: The watchdog register write (`wr_sel`=0) uses bit 7 as reload strobe, bit 6 as lock and bits 5:0 as timeout in ticks. A strobe, or an accepted timeout write, loads the counter. After T further ticks `wd_flag` sets on the T-th tick and the counter reloads T.
- R3: A timeout of 0 disables the watchdog: no number of ticks sets `wd_flag`.
- R4: A timeout field is taken only if the lock bit stored by the previous watchdog-register write is 0. Every watchdog-register write stores its own bit 6 as the new lock.
- R5: A one-cycle `alarm_evt` sets `alarm_flag`, and a one-cycle `pfail_evt` sets `pfail_flag`. Each flag is visible in the next cycle.
- R6: `flags_rd` clears all three flags. An event that arrives in the same cycle as the read wins, and its flag stays set.
- R7: The interrupt-control write (`wr_sel`=1) has bit 7 as watchdog enable, bit 6 as alarm enable and bit 5 as power-fail enable. A flag whose enable is 0 never activates the pin.
- R8: Interrupt-control bit 3 is the polarity. When it is 1 the active pin level is 1 and the idle level is 0. When it is 0 the levels are inverted.
- R9: With interrupt-control bit 2 at 0 (level mode), the pin is active while any enabled flag is set and returns to idle after `flags_rd`.
- R10: With bit 2 at 1 (pulse mode), an enabled event makes the pin active from the next cycle. It stays active for PULSE_TICKS ticks whether or not the flags are read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| tick_32hz | input | 1 | One-cycle strobe every 31.25 ms |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = watchdog register, 1 = interrupt-control register |
| wr_data | input | 8 | Register write data |
| flags_rd | input | 1 | Flags read strobe (clears flags) |
| alarm_evt | input | 1 | Alarm match event pulse |
| pfail_evt | input | 1 | Power-fail event pulse |
| wd_flag | output | 1 | Watchdog expiry flag |
| alarm_flag | output | 1 | Alarm flag |
| pfail_flag | output | 1 | Power-fail flag |
| irq_pin | output | 1 | Interrupt pin level |

## Verification
The bench keeps the default 6-bit timeout. It builds the block with PULSE_TICKS=3, so a whole pulse, its release and a polarity flip fit into a few tick strobes. Tick strobes come from the bench rather than a real 32 Hz divider. That lets it check exact tick counts for watchdog expiry at short timeouts, and it also shows that a zero timeout never expires over more ticks than the largest timeout allows.

// File: rtl/wdi_pkg.sv
package wdi_pkg;
  localparam int REG_W = 8;
  // watchdog register fields
  localparam int WD_STB_BIT  = 7;
  localparam int WD_LOCK_BIT = 6;
  // interrupt-control register fields
  localparam int IC_WIE_BIT  = 7;
  localparam int IC_AIE_BIT  = 6;
  localparam int IC_PFE_BIT  = 5;
  localparam int IC_POL_BIT  = 3;
  localparam int IC_MODE_BIT = 2;
  // flag vector order
  localparam int NFLAG  = 3;
  localparam int F_WD   = 0;
  localparam int F_ALM  = 1;
  localparam int F_PF   = 2;

  typedef struct packed {
    logic wie;
    logic aie;
    logic pfe;
    logic pol_hi;
    logic pulse_mode;
  } irq_cfg_t;
endpackage

// File: rtl/wdi_watchdog.sv
module wdi_watchdog
  import wdi_pkg::*;
#(
  parameter int TMO_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             expire
);
  logic [TMO_W-1:0] tmo_q, cnt_q, tmo_next;
  logic             lock_q;
  logic             take_tmo, reload;

  assign take_tmo = wr_en && !lock_q;
  assign tmo_next = take_tmo ? wr_data[TMO_W-1:0] : tmo_q;
  assign reload   = wr_en && (wr_data[WD_STB_BIT] || take_tmo);
  assign expire   = tick && !wr_en && (tmo_q != '0) && (cnt_q == TMO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q  <= '0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (wr_en) begin
      lock_q <= wr_data[WD_LOCK_BIT];
      tmo_q  <= tmo_next;
      if (reload) cnt_q <= tmo_next;
    end else if (tick && (tmo_q != '0)) begin
      if (cnt_q <= TMO_W'(1)) cnt_q <= tmo_q;
      else                    cnt_q <= cnt_q - TMO_W'(1);
    end
  end

  // R3
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q == '0) |-> (cnt_q == '0));
  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock_q) |=> $stable(tmo_q));
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q != '0) |-> ((cnt_q != '0) && (cnt_q <= tmo_q)));
endmodule

// File: rtl/wdi_flags.sv
module wdi_flags
  import wdi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_vec,
  input  logic             rd,
  output logic [NFLAG-1:0] flags
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          f_q <= 1'b0;
      else if (set_vec[i]) f_q <= 1'b1;
      else if (rd)         f_q <= 1'b0;
    end
    assign flags[i] = f_q;

    // R5
    set_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flags[i]);
    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !set_vec[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/wdi_pin.sv
module wdi_pin
  import wdi_pkg::*;
#(
  parameter int PULSE_TICKS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  irq_cfg_t         cfg,
  input  logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] trig_vec,
  output logic             irq_pin
);
  localparam int PW = $clog2(PULSE_TICKS + 1);

  logic [NFLAG-1:0] en_vec;
  logic [PW-1:0]    pcnt_q;
  logic             trig, level_on, on;

  assign en_vec   = {cfg.pfe, cfg.aie, cfg.wie};
  assign trig     = |(trig_vec & en_vec);
  assign level_on = |(flags & en_vec);
  assign on       = cfg.pulse_mode ? (pcnt_q != '0) : level_on;
  assign irq_pin  = cfg.pol_hi ? on : !on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pcnt_q <= '0;
    else if (trig && cfg.pulse_mode)     pcnt_q <= PW'(PULSE_TICKS);
    else if (tick && (pcnt_q != '0))     pcnt_q <= pcnt_q - PW'(1);
  end

  // R10
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pcnt_q == '0) && !trig) |=> (pcnt_q == '0));
  // R10
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= PW'(PULSE_TICKS));
endmodule

// File: rtl/wdog_irq_unit.sv
module wdog_irq_unit
  import wdi_pkg::*;
#(
  parameter int TMO_W       = 6,
  parameter int PULSE_TICKS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_32hz,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             flags_rd,
  input  logic             alarm_evt,
  input  logic             pfail_evt,
  output logic             wd_flag,
  output logic             alarm_flag,
  output logic             pfail_flag,
  output logic             irq_pin
);
  irq_cfg_t         cfg_q;
  logic             wd_exp;
  logic [NFLAG-1:0] set_vec, flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en && wr_sel) begin
      cfg_q.wie        <= wr_data[IC_WIE_BIT];
      cfg_q.aie        <= wr_data[IC_AIE_BIT];
      cfg_q.pfe        <= wr_data[IC_PFE_BIT];
      cfg_q.pol_hi     <= wr_data[IC_POL_BIT];
      cfg_q.pulse_mode <= wr_data[IC_MODE_BIT];
    end
  end

  wdi_watchdog #(.TMO_W(TMO_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .tick(tick_32hz),
    .wr_en(wr_en && !wr_sel), .wr_data(wr_data), .expire(wd_exp)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[F_WD]  = wd_exp;
    set_vec[F_ALM] = alarm_evt;
    set_vec[F_PF]  = pfail_evt;
  end

  wdi_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .rd(flags_rd), .flags(flags)
  );

  wdi_pin #(.PULSE_TICKS(PULSE_TICKS)) u_pin (
    .clk(clk), .rst_n(rst_n), .tick(tick_32hz), .cfg(cfg_q),
    .flags(flags), .trig_vec(set_vec), .irq_pin(irq_pin)
  );

  assign wd_flag    = flags[F_WD];
  assign alarm_flag = flags[F_ALM];
  assign pfail_flag = flags[F_PF];

  // R7
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.pulse_mode && ((flags & {cfg_q.pfe, cfg_q.aie, cfg_q.wie}) == '0))
      |-> (irq_pin == !cfg_q.pol_hi));
endmodule

// File: tb/wdog_irq_unit_bench.sv
module wdog_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32hz = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       flags_rd = 1'b0, alarm_evt = 1'b0, pfail_evt = 1'b0;
  logic       wd_flag, alarm_flag, pfail_flag, irq_pin;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_irq_unit #(.TMO_W(6), .PULSE_TICKS(3)) u_wdog_irq_unit (
    .clk(clk), .rst_n(rst_n), .tick_32hz(tick_32hz), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .flags_rd(flags_rd),
    .alarm_evt(alarm_evt), .pfail_evt(pfail_evt), .wd_flag(wd_flag),
    .alarm_flag(alarm_flag), .pfail_flag(pfail_flag), .irq_pin(irq_pin)
  );

  task automatic check(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", what, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic tick();
    @(negedge clk); tick_32hz = 1'b1;
    @(negedge clk); tick_32hz = 1'b0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask
  task automatic rd();
    @(negedge clk); flags_rd = 1'b1;
    @(negedge clk); flags_rd = 1'b0;
  endtask
  task automatic alarm();
    @(negedge clk); alarm_evt = 1'b1;
    @(negedge clk); alarm_evt = 1'b0;
  endtask
  task automatic pfail();
    @(negedge clk); pfail_evt = 1'b1;
    @(negedge clk); pfail_evt = 1'b0;
  endtask

  task automatic t_reset();
    check(wd_flag, 1'b0, "R1 wd_flag after reset");
    check(alarm_flag | pfail_flag, 1'b0, "R1 flags after reset");
    check(irq_pin, 1'b1, "R1 idle pin");
  endtask

  task automatic t_watchdog();
    wr(1'b0, 8'h83);
    ticks(2);
    check(wd_flag, 1'b0, "R2 before expiry");
    tick();
    check(wd_flag, 1'b1, "R2 on third tick");
    rd();
    check(wd_flag, 1'b0, "R6 read clears wd");
    ticks(2);
    check(wd_flag, 1'b0, "R2 restart not yet");
    tick();
    check(wd_flag, 1'b1, "R2 restart expiry");
    rd();
  endtask

  task automatic t_disable();
    wr(1'b0, 8'h80);
    ticks(70);
    check(wd_flag, 1'b0, "R3 zero timeout");
  endtask

  task automatic t_lock();
    wr(1'b0, 8'h45);
    wr(1'b0, 8'h82);
    ticks(4);
    check(wd_flag, 1'b0, "R4 locked timeout kept");
    tick();
    check(wd_flag, 1'b1, "R4 old timeout expires");
    rd();
    wr(1'b0, 8'h82);
    tick();
    check(wd_flag, 1'b0, "R4 unlocked new timeout pre");
    tick();
    check(wd_flag, 1'b1, "R4 unlocked new timeout");
    wr(1'b0, 8'h00);
    rd();
  endtask

  task automatic t_events();
    alarm();
    check(alarm_flag, 1'b1, "R5 alarm set");
    pfail();
    check(pfail_flag, 1'b1, "R5 pfail set");
    rd();
    check(alarm_flag | pfail_flag, 1'b0, "R6 read clears");
    @(negedge clk); flags_rd = 1'b1; alarm_evt = 1'b1;
    @(negedge clk); flags_rd = 1'b0; alarm_evt = 1'b0;
    check(alarm_flag, 1'b1, "R6 event wins over read");
    rd();
  endtask

  task automatic t_level();
    alarm();
    check(irq_pin, 1'b1, "R7 disabled alarm keeps pin idle");
    rd();
    wr(1'b1, 8'h48);
    check(irq_pin, 1'b0, "R8 idle low with high polarity");
    alarm();
    check(irq_pin, 1'b1, "R9 level active");
    ticks(8);
    check(irq_pin, 1'b1, "R9 level held");
    rd();
    check(irq_pin, 1'b0, "R9 read releases");
    pfail();
    check(irq_pin, 1'b0, "R7 pfail not enabled");
    rd();
  endtask

  task automatic t_pulse();
    wr(1'b1, 8'h4C);
    alarm();
    check(irq_pin, 1'b1, "R10 pulse starts");
    rd();
    ticks(2);
    check(irq_pin, 1'b1, "R10 pulse survives read");
    tick();
    check(irq_pin, 1'b0, "R10 pulse ends");
    wr(1'b1, 8'h44);
    check(irq_pin, 1'b1, "R8 idle high low polarity");
    alarm();
    check(irq_pin, 1'b0, "R8 active-low pulse");
    ticks(3);
    check(irq_pin, 1'b1, "R10 active-low pulse ends");
    rd();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_watchdog();
    t_disable();
    t_lock();
    t_events();
    t_level();
    t_pulse();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule